// File: doc/BRIEF.md
# Protected Scratchpad Page Write Controller

This block stages writes into a small non-volatile store through a 32-byte scratchpad. It takes whole bytes from a command front end (bit timing and device selection happen upstream) and answers read requests one byte at a time. A host first fills the scratchpad with a write command and can read it back to confirm the target address, the ending offset and the flags. It then issues a copy command that repeats the address and status bytes as an authorisation. After a fixed programming delay the scratchpad contents move into the addressed row of the store.

The store holds 16 data rows of 32 bytes plus one 32-byte register row at 0200h–021Fh. The byte at 0200h+n guards data row n: 55h makes it write-protected, AAh lets stored bits only fall from 1 to 0. The byte at 0210h is a lock. When it holds 55h or AAh, copies into the register row and into write-protected rows are refused. A side read port lets a neighbouring read path fetch any stored byte.

Top module: `scratch_copy_ctrl`

## Requirements
- R1: After reset every stored byte reads FFh through the side port, and a read request returns FFh.
- R2: Command 0Fh is followed by the target address low byte, then the high byte. The scratchpad offset becomes address bits 4:0. PF and AA are cleared. Each later data byte lands at the current offset, and the offset then steps by one. Bytes that arrive after offset 31 has been filled are dropped. The ending offset is the last offset written.
- R3: Command AAh returns the address low byte, the address high byte and the status byte, in that order. It then returns scratchpad bytes from the start offset up to offset 31, and FFh after that. The status byte is {AA, 0, PF, ending offset[4:0]}.
- R4: A bus reset that arrives with a byte fragment during the data phase of 0Fh sets PF. The next 0Fh command clears it.
- R5: Command 55h followed by the exact address low byte, address high byte and status byte starts a copy. Reads return 00h while programming runs, which lasts PROG_CYCLES cycles. The copy then writes scratchpad offsets start..end into the same offsets of the target row and sets AA. Every read then returns AAh until a bus reset.
- R6: A copy whose echo differs in any byte starts nothing and changes no stored byte. Later reads return FFh.
- R7: A copy is refused while PF is set. AA is never set together with PF.
- R8: With protection byte 55h and no lock, a copy into that row completes and sets AA, but it leaves the row unchanged.
- R9: With protection byte AAh, a copy stores old AND new.
- R10: With lock 55h or AAh at 0210h, copies into the register row or into a write-protected row are refused. Copies into other rows still complete.
- R11: Copies whose target is 0220h or above are refused.
- R12: A bus reset returns the block to the command phase from any command. A copy that has been accepted still completes.
- R13: The read byte changes only in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset seen by the front end |
| rx_frag | input | 1 | With bus_rst: a byte was partly received |
| rx_valid | input | 1 | A byte from the host is present |
| rx_byte | input | 8 | Byte from the host |
| rd_req | input | 1 | Host asks for the next byte |
| rd_data | output | 8 | Byte returned to the host |
| mem_raddr | input | 10 | Side read address into the store |
| mem_rdata | output | 8 | Stored byte at mem_raddr (FFh outside the store) |

## Verification
A byte on rx_valid takes effect at the clock edge that samples it. A read request returns its byte in the next cycle, so the bench samples rd_data at the falling edge after the request's rising edge.

An accepted copy writes to the store PROG_CYCLES edges after the final echo byte. The bench first reads once right after the echo to see the 00h busy value. It then waits PROG_CYCLES plus a margin before it checks the store or the AAh confirmation.

Side port reads are combinational, so they are sampled shortly after the address is driven.

// File: rtl/scratch_copy_ctrl.sv
module scratch_copy_ctrl #(
  parameter int PAGES       = 16,
  parameter int ROW         = 32,
  parameter int PROG_CYCLES = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       rx_frag,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rd_req,
  output logic [7:0] rd_data,
  input  logic [9:0] mem_raddr,
  output logic [7:0] mem_rdata
);
  localparam int OW       = $clog2(ROW);
  localparam int REG_BASE = PAGES * ROW;
  localparam int TOTAL    = REG_BASE + ROW;
  localparam int AW       = 10;
  localparam int CW       = $clog2(PROG_CYCLES + 1);
  localparam logic [7:0] CMD_WR = 8'h0F, CMD_RD = 8'hAA, CMD_CP = 8'h55;

  typedef enum logic [3:0] {S_CMD, S_WA1, S_WA2, S_WDAT, S_RD, S_CA1, S_CA2, S_CES,
                            S_PROG, S_DONE, S_MUTE} st_t;
  st_t st;

  logic [7:0]    mem [TOTAL];
  logic [7:0]    sp  [ROW];
  logic [15:0]   ta;
  logic [OW:0]   off, rptr;
  logic [OW-1:0] ends;
  logic          pf, aa, echo_ok, rst_seen;
  logic [1:0]    ridx;
  logic [CW-1:0] cnt;

  wire [7:0]    esb     = {aa, 1'b0, pf, ends};
  wire          addr_ok = ta < 16'(TOTAL);
  wire          in_reg  = ta >= 16'(REG_BASE);
  wire [AW-1:0] prot_ix = AW'(REG_BASE) + {{OW{1'b0}}, ta[AW-1:OW]};
  wire [7:0]    prot    = mem[prot_ix];
  wire [7:0]    lockb   = mem[REG_BASE + PAGES];
  wire          locked  = lockb == 8'h55 || lockb == 8'hAA;
  wire          wp      = !in_reg && prot == 8'h55;
  wire          ep      = !in_reg && prot == 8'hAA;
  wire          blocked = locked && (in_reg || wp);
  wire          in_prog = st == S_PROG;
  wire          prog_fire = in_prog && cnt == CW'(PROG_CYCLES - 1);

  assign mem_rdata = (mem_raddr < AW'(TOTAL)) ? mem[mem_raddr] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; ta <= '0; off <= '0; ends <= '0; pf <= 1'b0; aa <= 1'b0;
      echo_ok <= 1'b0; rst_seen <= 1'b0; cnt <= '0; ridx <= '0; rptr <= '0;
      rd_data <= 8'hFF;
    end else begin
      if (rd_req) begin
        case (st)
          S_RD: begin
            case (ridx)
              2'd0:    rd_data <= ta[7:0];
              2'd1:    rd_data <= ta[15:8];
              2'd2:    rd_data <= esb;
              default: rd_data <= rptr[OW] ? 8'hFF : sp[rptr[OW-1:0]];
            endcase
            if (ridx != 2'd3) ridx <= ridx + 2'd1;
            else if (!rptr[OW]) rptr <= rptr + 1'b1;
          end
          S_PROG:  rd_data <= 8'h00;
          S_DONE:  rd_data <= 8'hAA;
          default: rd_data <= 8'hFF;
        endcase
      end
      if (in_prog && !prog_fire) cnt <= cnt + 1'b1;
      if (prog_fire) begin
        aa <= 1'b1;
        st <= rst_seen ? S_CMD : S_DONE;
      end else if (bus_rst) begin
        if (in_prog) rst_seen <= 1'b1;
        else st <= S_CMD;
        if (st == S_WDAT && rx_frag) pf <= 1'b1;
      end else if (rx_valid) begin
        case (st)
          S_CMD: begin
            if (rx_byte == CMD_WR) st <= S_WA1;
            else if (rx_byte == CMD_RD) begin
              st <= S_RD; ridx <= '0; rptr <= {1'b0, ta[OW-1:0]};
            end else if (rx_byte == CMD_CP) begin
              st <= S_CA1; echo_ok <= 1'b1;
            end else st <= S_MUTE;
          end
          S_WA1: begin ta[7:0] <= rx_byte; st <= S_WA2; end
          S_WA2: begin
            ta[15:8] <= rx_byte; off <= {1'b0, ta[OW-1:0]}; ends <= ta[OW-1:0];
            pf <= 1'b0; aa <= 1'b0; st <= S_WDAT;
          end
          S_WDAT: if (!off[OW]) begin ends <= off[OW-1:0]; off <= off + 1'b1; end
          S_CA1: begin echo_ok <= echo_ok && rx_byte == ta[7:0]; st <= S_CA2; end
          S_CA2: begin echo_ok <= echo_ok && rx_byte == ta[15:8]; st <= S_CES; end
          S_CES: begin
            if (echo_ok && rx_byte == esb && !pf && addr_ok && !blocked) begin
              st <= S_PROG; cnt <= '0; rst_seen <= 1'b0;
            end else st <= S_MUTE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk)
    if (st == S_WDAT && rx_valid && !bus_rst && !off[OW]) sp[off[OW-1:0]] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= 8'hFF;
    end else if (prog_fire) begin
      for (int i = 0; i < ROW; i++)
        if (OW'(i) >= ta[OW-1:0] && OW'(i) <= ends)
          mem[{ta[AW-1:OW], i[OW-1:0]}] <= wp ? mem[{ta[AW-1:OW], i[OW-1:0]}]
                                         : ep ? (mem[{ta[AW-1:OW], i[OW-1:0]}] & sp[i])
                                         : sp[i];
    end
  end
endmodule

module scc_chk #(parameter int AW = 10) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [7:0]    rd_data,
  input logic [7:0]    es_byte,
  input logic          prog_fire,
  input logic          in_prog,
  input logic [AW-1:0] mem_raddr,
  input logic [7:0]    mem_rdata
);
  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_req) |-> $stable(rd_data));
  // R7
  aa_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    es_byte[7] |-> !es_byte[5]);
  // R6
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_fire |=> ($stable(mem_raddr) -> $stable(mem_rdata)));
  // R5
  done_aa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |=> es_byte[7]);
  // R12
  prog_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_prog && !prog_fire |=> in_prog);
endmodule

bind scratch_copy_ctrl scc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_data(rd_data), .es_byte(esb),
  .prog_fire(prog_fire), .in_prog(in_prog), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata));

// File: tb/sim_scratch_copy_ctrl.sv
module sim_scratch_copy_ctrl;
  localparam int PROG = 20;
  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0, rx_frag = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] rx_byte = 8'h00, rd_data, mem_rdata;
  logic [9:0] mem_raddr = '0;
  int runs = 0, fails = 0;
  logic [7:0] b;

  always #5 clk = ~clk;

  scratch_copy_ctrl #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_frag(rx_frag), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rd_req(rd_req), .rd_data(rd_data), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata));

  localparam logic [23:0] VEC [8] = '{
    {16'h0000, 8'h11}, {16'h0021, 8'h22}, {16'h005F, 8'h33}, {16'h01E0, 8'h44},
    {16'h01FF, 8'h55}, {16'h0104, 8'hA5}, {16'h0080, 8'h00}, {16'h01C3, 8'h7E}};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v);
    @(negedge clk); rx_byte = v; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brst(input logic frag);
    @(negedge clk); bus_rst = 1'b1; rx_frag = frag;
    @(negedge clk); bus_rst = 1'b0; rx_frag = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; v = rd_data;
  endtask

  task automatic peek(input logic [9:0] a, output logic [7:0] v);
    @(negedge clk); mem_raddr = a; #1; v = mem_rdata;
  endtask

  task automatic ws(input logic [15:0] a, input logic [7:0] d0, input int n);
    brst(1'b0); send(8'h0F); send(a[7:0]); send(a[15:8]);
    for (int i = 0; i < n; i++) send(d0 + 8'(i));
  endtask

  task automatic cp(input logic [15:0] a, input logic [7:0] es);
    brst(1'b0); send(8'h55); send(a[7:0]); send(a[15:8]); send(es);
    repeat (PROG + 3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(b); chk("R1 read after reset", b, 8'hFF);
    peek(10'h000, b); chk("R1 store erased", b, 8'hFF);
    peek(10'h21F, b); chk("R1 register row erased", b, 8'hFF);

    for (int k = 0; k < 8; k++) begin
      ws(VEC[k][23:8], VEC[k][7:0], 1);
      cp(VEC[k][23:8], {3'b000, VEC[k][12:8]});
      peek(VEC[k][17:8], b); chk("R5 table copy", b, VEC[k][7:0]);
    end

    // R2/R3: start offset 5, 30 bytes, only 27 fit
    ws(16'h0045, 8'h10, 30);
    brst(1'b0); send(8'hAA);
    rd(b); chk("R3 address low", b, 8'h45);
    rd(b); chk("R3 address high", b, 8'h00);
    rd(b); chk("R2 ending offset 31", b, 8'h1F);
    rd(b); chk("R2 first byte at start offset", b, 8'h10);
    for (int i = 1; i < 27; i++) rd(b);
    chk("R2 last byte at offset 31", b, 8'h2A);
    rd(b); chk("R3 past end of row", b, 8'hFF);

    // R12: abort copy echo, next byte is a command
    ws(16'h0060, 8'h70, 2);
    brst(1'b0); send(8'h55); send(8'h60); brst(1'b0); send(8'hAA);
    rd(b); chk("R12 abort returns to command phase", b, 8'h60);

    // R4 / R7
    ws(16'h0060, 8'h70, 2); brst(1'b1);
    brst(1'b0); send(8'hAA); rd(b); rd(b); rd(b);
    chk("R4 PF set by fragment", b, 8'h21);
    cp(16'h0060, 8'h21);
    rd(b); chk("R7 copy refused with PF", b, 8'hFF);
    peek(10'h060, b); chk("R7 store unchanged", b, 8'hFF);
    ws(16'h0060, 8'h70, 2);
    brst(1'b0); send(8'hAA); rd(b); rd(b); rd(b);
    chk("R4 PF cleared by new write", b, 8'h01);

    // R6
    cp(16'h0060, 8'h02);
    rd(b); chk("R6 bad status echo", b, 8'hFF);
    cp(16'h0160, 8'h01);
    peek(10'h060, b); chk("R6 store unchanged", b, 8'hFF);

    // R5 timing
    brst(1'b0); send(8'h55); send(8'h60); send(8'h00); send(8'h01);
    rd(b); chk("R5 busy while programming", b, 8'h00);
    repeat (PROG + 2) @(negedge clk);
    rd(b); chk("R5 confirmation", b, 8'hAA);
    rd(b); chk("R5 confirmation repeats", b, 8'hAA);
    peek(10'h060, b); chk("R5 first byte copied", b, 8'h70);
    peek(10'h061, b); chk("R5 second byte copied", b, 8'h71);
    brst(1'b0); send(8'hAA); rd(b); rd(b); rd(b);
    chk("R5 AA in status", b, 8'h81);

    // R12: accepted copy survives bus reset
    ws(16'h00A0, 8'h5A, 1);
    brst(1'b0); send(8'h55); send(8'hA0); send(8'h00); send(8'h00); brst(1'b0);
    repeat (PROG + 3) @(negedge clk);
    peek(10'h0A0, b); chk("R12 committed copy completes", b, 8'h5A);
    rd(b); chk("R12 no confirmation after reset", b, 8'hFF);

    // R9: row 3 in EPROM mode
    ws(16'h0203, 8'hAA, 1); cp(16'h0203, 8'h03);
    peek(10'h203, b); chk("R9 protection byte stored", b, 8'hAA);
    ws(16'h0060, 8'h3C, 1); cp(16'h0060, 8'h00);
    peek(10'h060, b); chk("R9 old AND new", b, 8'h30);

    // R8: row 4 write-protected
    ws(16'h0204, 8'h55, 1); cp(16'h0204, 8'h04);
    ws(16'h0080, 8'hEE, 1); cp(16'h0080, 8'h00);
    rd(b); chk("R8 copy confirmed", b, 8'hAA);
    peek(10'h080, b); chk("R8 row unchanged", b, 8'h00);

    // R10: lock
    ws(16'h0210, 8'h55, 1); cp(16'h0210, 8'h10);
    peek(10'h210, b); chk("R10 lock stored", b, 8'h55);
    ws(16'h0081, 8'h12, 1); cp(16'h0081, 8'h01);
    rd(b); chk("R10 locked protected row refused", b, 8'hFF);
    peek(10'h081, b); chk("R10 protected row unchanged", b, 8'hFF);
    ws(16'h0205, 8'h55, 1); cp(16'h0205, 8'h05);
    peek(10'h205, b); chk("R10 register row locked", b, 8'hFF);
    ws(16'h0140, 8'h9A, 1); cp(16'h0140, 8'h00);
    peek(10'h140, b); chk("R10 free row still copies", b, 8'h9A);

    // R11
    ws(16'h0220, 8'h01, 1); cp(16'h0220, 8'h00);
    rd(b); chk("R11 target beyond store", b, 8'hFF);
    ws(16'h1000, 8'h01, 1); cp(16'h1000, 8'h00);
    rd(b); chk("R11 high address refused", b, 8'hFF);
    peek(10'h000, b); chk("R11 aliased row untouched", b, 8'h11);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule